// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Capacity Sharing

This block tracks in-flight instructions for up to four hardware threads. Each thread has its own first-in first-out queue of entries, holding a sequence number, a valid bit and a ready-to-commit bit. All threads draw on one shared total capacity. A sharing policy gives each thread an entry limit, and that limit follows the current policy and active-thread mask with no added delay.

The front end allocates one entry per cycle, naming the thread, the sequence number and whether the instruction is already complete. The block returns the slot index it used. Execution units later mark entries complete by thread and slot. The commit stage reads each thread's head and asks to retire it. A retire request succeeds only when that head is present and ready. The block reports per-thread and total free counts, per-thread head status, and a flag that is high when some active thread could commit.

Top module: `mt_rob`

## Requirements
- R1: After reset every queue is empty, `head_valid_o` and `head_ready_o` are all zero, `commit_ok_o` is 0 and `total_free_o` equals DEPTH.
- R2: With `policy_i` = 0 (dynamic) or 3 (reserved, treated as dynamic), every thread's limit is DEPTH.
- R3: With `policy_i` = 1 (partitioned), each active thread's limit is DEPTH divided by the number of active threads, rounded down. Inactive threads, and all threads when none is active, get DEPTH/NTHR.
- R4: With `policy_i` = 2 (threshold), every thread's limit is THRESH, except when exactly one thread is active: that thread's limit is DEPTH.
- R5: Thread t's free count (`free_cnt_o` bits [t*CW +: CW], CW = clog2(DEPTH+1)) is its limit minus its occupancy, saturating at 0. `total_free_o` is DEPTH minus the total occupancy. Limits follow `policy_i` and `active_i` in the same cycle.
- R6: An allocation is accepted (`alloc_ok_o` = 1) when the thread's free count is nonzero and the total occupancy is below DEPTH. The entry is appended at that thread's tail, and `alloc_slot_o` shows that slot in the same cycle. Occupancies rise at the next clock edge.
- R7: A refused allocation raises `alloc_err_o` in the same cycle and changes no state.
- R8: Setting `retire_i[t]` removes thread t's head at the next edge only if that head is valid and ready. Otherwise the request is ignored. An accepted allocation and a retire may happen in the same cycle.
- R9: `head_valid_o[t]` and `head_seq_o` bits [t*SEQW +: SEQW] give thread t's oldest entry. `head_ready_o[t]` is 0 whenever thread t is empty.
- R10: A completion (`cmpl_valid_i`, `cmpl_tid_i`, `cmpl_slot_i`) marks an occupied slot ready, visible from the next cycle. A completion to an unoccupied slot has no effect.
- R11: `commit_ok_o` is 1 exactly when some thread that is set in `active_i` has a ready head.
- R12: Each thread retires its entries in allocation order, across wrap-around of its circular queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing policy code: 0 dynamic, 1 partitioned, 2 threshold, 3 reserved |
| active_i | input | NTHR | Active-thread mask |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_tid_i | input | clog2(NTHR) | Thread of the allocation |
| alloc_seq_i | input | SEQW | Sequence number of the new entry |
| alloc_ready_i | input | 1 | New entry is already ready to commit |
| cmpl_valid_i | input | 1 | Completion update |
| cmpl_tid_i | input | clog2(NTHR) | Thread of the completion |
| cmpl_slot_i | input | clog2(DEPTH) | Slot of the completion |
| retire_i | input | NTHR | Per-thread retire request |
| alloc_ok_o | output | 1 | Allocation accepted this cycle |
| alloc_err_o | output | 1 | Allocation refused this cycle |
| alloc_slot_o | output | clog2(DEPTH) | Slot the allocation uses |
| free_cnt_o | output | NTHR*CW | Per-thread free-entry counts |
| total_free_o | output | CW | Free entries in total |
| head_valid_o | output | NTHR | Per-thread queue is non-empty |
| head_ready_o | output | NTHR | Per-thread head is ready to commit |
| head_seq_o | output | NTHR*SEQW | Per-thread head sequence number (0 when empty) |
| commit_ok_o | output | 1 | Some active thread can commit |

## Verification
The hardest case to reach is a thread whose circular pointers wrap. It must happen while other threads keep entries that are not ready, so the total capacity stays partly taken. The stimulus first fills one thread to its limit under the threshold policy, then fills the whole buffer from another thread, then drains the first thread and switches to the dynamic policy. It then runs twelve allocate-and-retire rounds on that thread, and the pointers pass the end of the queue. Before this, lowering the limits under the partitioned policy drives free counts into saturation. A same-cycle allocate and retire checks that the two counter updates combine.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;
  typedef enum logic [1:0] {
    POL_DYN  = 2'd0,
    POL_PART = 2'd1,
    POL_THR  = 2'd2,
    POL_RSV  = 2'd3
  } share_pol_e;
endpackage

// File: rtl/mt_rob_limit.sv
module mt_rob_limit
  import mt_rob_pkg::*;
#(
  parameter int NTHR   = 4,
  parameter int DEPTH  = 16,
  parameter int THRESH = 6,
  parameter int CW     = 5
) (
  input  logic [1:0]                   policy_i,
  input  logic [NTHR-1:0]              active_i,
  output logic [NTHR-1:0][CW-1:0]      lim_o
);
  localparam int NAW = $clog2(NTHR + 1);
  localparam logic [CW-1:0] BASE_Q = CW'(DEPTH / NTHR);
  localparam logic [CW-1:0] FULL_Q = CW'(DEPTH);
  localparam logic [CW-1:0] THR_Q  = CW'(THRESH);

  share_pol_e      pol;
  logic [NAW-1:0]  nact;
  logic [CW-1:0]   part_q;

  // quotient of DEPTH by the active count, selected from constants
  always_comb begin
    pol  = share_pol_e'(policy_i);
    nact = '0;
    for (int t = 0; t < NTHR; t++) nact = nact + NAW'(active_i[t]);
    part_q = BASE_Q;
    for (int k = 1; k <= NTHR; k++) begin
      if (nact == NAW'(k)) part_q = CW'(DEPTH / k);
    end
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      case (pol)
        POL_PART: lim_o[t] = (active_i[t] && nact != '0) ? part_q : BASE_Q;
        POL_THR:  lim_o[t] = (active_i[t] && nact == NAW'(1)) ? FULL_Q : THR_Q;
        default:  lim_o[t] = FULL_Q;
      endcase
    end
  end
endmodule

// File: rtl/mt_rob_tq.sv
module mt_rob_tq #(
  parameter int DEPTH = 16,
  parameter int SEQW  = 16,
  parameter int PW    = 4,
  parameter int CW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [SEQW-1:0] push_seq_i,
  input  logic            push_rdy_i,
  input  logic            pop_req_i,
  input  logic            cmpl_i,
  input  logic [PW-1:0]   cmpl_slot_i,
  output logic [PW-1:0]   tail_o,
  output logic [CW-1:0]   occ_o,
  output logic            head_valid_o,
  output logic            head_ready_o,
  output logic [SEQW-1:0] head_seq_o,
  output logic            pop_o
);
  logic [PW-1:0]    hd_q, hd_d, tl_q, tl_d;
  logic [CW-1:0]    occ_q, occ_d;
  logic [DEPTH-1:0] vld_q, vld_d, rdy_q, rdy_d;
  logic [SEQW-1:0]  seq_q [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign tail_o       = tl_q;
  assign occ_o        = occ_q;
  assign head_valid_o = vld_q[hd_q];
  assign head_ready_o = vld_q[hd_q] & rdy_q[hd_q];
  assign head_seq_o   = head_valid_o ? seq_q[hd_q] : '0;
  assign pop_o        = pop_req_i & head_ready_o;

  always_comb begin
    vld_d = vld_q;
    rdy_d = rdy_q;
    if (cmpl_i && (32'(cmpl_slot_i) < DEPTH) && vld_q[cmpl_slot_i])
      rdy_d[cmpl_slot_i] = 1'b1;
    if (pop_o) vld_d[hd_q] = 1'b0;
    if (push_i) begin
      vld_d[tl_q] = 1'b1;
      rdy_d[tl_q] = push_rdy_i;
    end
    hd_d  = pop_o  ? bump(hd_q) : hd_q;
    tl_d  = push_i ? bump(tl_q) : tl_q;
    occ_d = occ_q + CW'(push_i) - CW'(pop_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      occ_q <= '0;
      vld_q <= '0;
    end else begin
      hd_q  <= hd_d;
      tl_q  <= tl_d;
      occ_q <= occ_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    rdy_q <= rdy_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) seq_q[tl_q] <= push_seq_i;
  end
endmodule

// File: rtl/mt_rob.sv
module mt_rob
  import mt_rob_pkg::*;
#(
  parameter int NTHR   = 4,
  parameter int DEPTH  = 16,
  parameter int SEQW   = 16,
  parameter int THRESH = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [1:0]                          policy_i,
  input  logic [NTHR-1:0]                     active_i,
  input  logic                                alloc_valid_i,
  input  logic [$clog2(NTHR)-1:0]             alloc_tid_i,
  input  logic [SEQW-1:0]                     alloc_seq_i,
  input  logic                                alloc_ready_i,
  input  logic                                cmpl_valid_i,
  input  logic [$clog2(NTHR)-1:0]             cmpl_tid_i,
  input  logic [$clog2(DEPTH)-1:0]            cmpl_slot_i,
  input  logic [NTHR-1:0]                     retire_i,
  output logic                                alloc_ok_o,
  output logic                                alloc_err_o,
  output logic [$clog2(DEPTH)-1:0]            alloc_slot_o,
  output logic [NTHR*$clog2(DEPTH+1)-1:0]     free_cnt_o,
  output logic [$clog2(DEPTH+1)-1:0]          total_free_o,
  output logic [NTHR-1:0]                     head_valid_o,
  output logic [NTHR-1:0]                     head_ready_o,
  output logic [NTHR*SEQW-1:0]                head_seq_o,
  output logic                                commit_ok_o
);
  localparam int TW = $clog2(NTHR);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NTHR-1:0][CW-1:0] lim_w, occ_w, free_w;
  logic [NTHR-1:0][PW-1:0] tail_w;
  logic [NTHR-1:0]         pop_w;
  logic [CW-1:0]           tot_q, tot_d;
  logic [CW-1:0]           sel_free;
  logic [PW-1:0]           sel_tail;
  logic                    sel_hit;

  mt_rob_limit #(
    .NTHR(NTHR), .DEPTH(DEPTH), .THRESH(THRESH), .CW(CW)
  ) limit_i (
    .policy_i (policy_i),
    .active_i (active_i),
    .lim_o    (lim_w)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic push_t, cmpl_t;
    assign push_t = alloc_ok_o && (alloc_tid_i == TW'(t));
    assign cmpl_t = cmpl_valid_i && (cmpl_tid_i == TW'(t));

    mt_rob_tq #(
      .DEPTH(DEPTH), .SEQW(SEQW), .PW(PW), .CW(CW)
    ) tq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (push_t),
      .push_seq_i   (alloc_seq_i),
      .push_rdy_i   (alloc_ready_i),
      .pop_req_i    (retire_i[t]),
      .cmpl_i       (cmpl_t),
      .cmpl_slot_i  (cmpl_slot_i),
      .tail_o       (tail_w[t]),
      .occ_o        (occ_w[t]),
      .head_valid_o (head_valid_o[t]),
      .head_ready_o (head_ready_o[t]),
      .head_seq_o   (head_seq_o[t*SEQW +: SEQW]),
      .pop_o        (pop_w[t])
    );

    assign free_w[t] = (lim_w[t] > occ_w[t]) ? (lim_w[t] - occ_w[t]) : '0;
    assign free_cnt_o[t*CW +: CW] = free_w[t];
  end

  always_comb begin
    sel_free = '0;
    sel_tail = '0;
    sel_hit  = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      if (alloc_tid_i == TW'(t)) begin
        sel_free = free_w[t];
        sel_tail = tail_w[t];
        sel_hit  = 1'b1;
      end
    end
  end

  assign alloc_ok_o   = alloc_valid_i && sel_hit && (sel_free != '0) &&
                        (tot_q != CW'(DEPTH));
  assign alloc_err_o  = alloc_valid_i && !alloc_ok_o;
  assign alloc_slot_o = sel_tail;
  assign total_free_o = CW'(DEPTH) - tot_q;
  assign commit_ok_o  = |(head_ready_o & active_i);

  always_comb begin
    tot_d = tot_q + CW'(alloc_ok_o);
    for (int t = 0; t < NTHR; t++) tot_d = tot_d - CW'(pop_w[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tot_q <= '0;
    else        tot_q <= tot_d;
  end
endmodule

// File: rtl/mt_rob_chk.sv
module mt_rob_chk #(
  parameter int NTHR  = 4,
  parameter int DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NTHR-1:0]             active_i,
  input logic [NTHR-1:0]             retire_i,
  input logic                        alloc_ok_o,
  input logic                        alloc_err_o,
  input logic [$clog2(DEPTH+1)-1:0]  total_free_o,
  input logic [NTHR-1:0]             head_valid_o,
  input logic [NTHR-1:0]             head_ready_o,
  input logic                        commit_ok_o
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok_o |-> total_free_o != '0);

  a_r6_alloc_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok_o && (retire_i & head_ready_o) == '0)
      |=> total_free_o == $past(total_free_o) - CW'(1));

  a_r8_retire_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ok_o && (retire_i & head_ready_o) == '0) |=> $stable(total_free_o));

  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err_o |-> !alloc_ok_o);

  a_r5_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    total_free_o <= CW'(DEPTH));

  a_r11_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ready_o & active_i) == '0 |-> !commit_ok_o);

  for (genvar t = 0; t < NTHR; t++) begin : g_hd
    a_r9_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid_o[t] |-> !head_ready_o[t]);
  end
endmodule

bind mt_rob mt_rob_chk #(.NTHR(NTHR), .DEPTH(DEPTH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .active_i     (active_i),
  .retire_i     (retire_i),
  .alloc_ok_o   (alloc_ok_o),
  .alloc_err_o  (alloc_err_o),
  .total_free_o (total_free_o),
  .head_valid_o (head_valid_o),
  .head_ready_o (head_ready_o),
  .commit_ok_o  (commit_ok_o)
);

// File: tb/mt_rob_tb_top.sv
module mt_rob_tb_top;
  localparam int NTHR = 4, DEPTH = 16, SEQW = 16, THRESH = 6;
  localparam int CW = $clog2(DEPTH + 1);

  // time unit 1 ns: 20 ns period, 50 MHz
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic [1:0]       policy;
  logic [NTHR-1:0]  active;
  logic             alloc_valid;
  logic [1:0]       alloc_tid;
  logic [SEQW-1:0]  alloc_seq;
  logic             alloc_ready;
  logic             cmpl_valid;
  logic [1:0]       cmpl_tid;
  logic [3:0]       cmpl_slot;
  logic [NTHR-1:0]  retire;
  logic             alloc_ok, alloc_err;
  logic [3:0]       alloc_slot;
  logic [NTHR*CW-1:0]   free_cnt;
  logic [CW-1:0]    total_free;
  logic [NTHR-1:0]  head_valid, head_ready;
  logic [NTHR*SEQW-1:0] head_seq;
  logic             commit_ok;

  int errs = 0, checks = 0;
  bit done = 0;

  mt_rob #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQW(SEQW), .THRESH(THRESH)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .active_i(active),
    .alloc_valid_i(alloc_valid), .alloc_tid_i(alloc_tid), .alloc_seq_i(alloc_seq),
    .alloc_ready_i(alloc_ready), .cmpl_valid_i(cmpl_valid), .cmpl_tid_i(cmpl_tid),
    .cmpl_slot_i(cmpl_slot), .retire_i(retire), .alloc_ok_o(alloc_ok),
    .alloc_err_o(alloc_err), .alloc_slot_o(alloc_slot), .free_cnt_o(free_cnt),
    .total_free_o(total_free), .head_valid_o(head_valid), .head_ready_o(head_ready),
    .head_seq_o(head_seq), .commit_ok_o(commit_ok)
  );

  function automatic int free_of(int t);
    return int'(free_cnt[t*CW +: CW]);
  endfunction
  function automatic int seq_of(int t);
    return int'(head_seq[t*SEQW +: SEQW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    alloc_valid = 0; cmpl_valid = 0; retire = '0;
    alloc_tid = 0; alloc_seq = 0; alloc_ready = 0; cmpl_tid = 0; cmpl_slot = 0;
  endtask

  task automatic alloc1(int tid, int seq, bit rdy, int exp_slot, string tag);
    alloc_valid = 1; alloc_tid = 2'(tid); alloc_seq = SEQW'(seq); alloc_ready = rdy;
    #1;
    chk({tag, " R6 slot"}, int'(alloc_slot), exp_slot);
    chk({tag, " R6 accepted"}, int'(alloc_ok), 1);
    tick();
    alloc_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 total free", int'(total_free), DEPTH);
    chk("R1 head valid", int'(head_valid), 0);
    chk("R1 head ready", int'(head_ready), 0);
    chk("R1 commit ok", int'(commit_ok), 0);
    for (int t = 0; t < NTHR; t++) chk("R1 R2 free after reset", free_of(t), DEPTH);
  endtask

  task automatic t_policy();
    policy = 2'd1; active = 4'b1111; #1;
    for (int t = 0; t < NTHR; t++) chk("R3 four active", free_of(t), 4);
    active = 4'b0011; #1;
    chk("R3 two active t0", free_of(0), 8);
    chk("R3 two active t1", free_of(1), 8);
    chk("R3 inactive t2", free_of(2), 4);
    active = 4'b0000; #1;
    chk("R3 none active", free_of(3), 4);
    active = 4'b0111; #1;
    chk("R3 three active", free_of(0), 5);
    policy = 2'd2; active = 4'b1111; #1;
    chk("R4 threshold", free_of(1), THRESH);
    active = 4'b0100; #1;
    chk("R4 single active full", free_of(2), DEPTH);
    chk("R4 other thread", free_of(0), THRESH);
    policy = 2'd3; #1;
    chk("R2 reserved code", free_of(0), DEPTH);
    policy = 2'd0; active = 4'b1111; #1;
    chk("R2 dynamic", free_of(3), DEPTH);
  endtask

  task automatic t_alloc_order();
    alloc1(1, 100, 0, 0, "t1 a");
    alloc1(1, 101, 0, 1, "t1 b");
    alloc1(1, 102, 0, 2, "t1 c");
    chk("R5 thread free", free_of(1), 13);
    chk("R5 total free", int'(total_free), 13);
    chk("R9 head valid", int'(head_valid[1]), 1);
    chk("R9 head seq", seq_of(1), 100);
    chk("R9 head not ready", int'(head_ready[1]), 0);
    chk("R11 no commit", int'(commit_ok), 0);
  endtask

  task automatic t_cmpl_empty();
    cmpl_valid = 1; cmpl_tid = 2; cmpl_slot = 0;
    tick(); cmpl_valid = 0; #1;
    chk("R10 empty slot head valid", int'(head_valid[2]), 0);
    chk("R10 empty slot ready", int'(head_ready[2]), 0);
    chk("R10 empty slot free", free_of(2), DEPTH);
  endtask

  task automatic t_complete();
    cmpl_valid = 1; cmpl_tid = 1; cmpl_slot = 1;
    tick(); cmpl_valid = 0; #1;
    chk("R10 non-head completion", int'(head_ready[1]), 0);
    cmpl_valid = 1; cmpl_tid = 1; cmpl_slot = 0; #1;
    chk("R10 not yet visible", int'(head_ready[1]), 0);
    tick(); cmpl_valid = 0; #1;
    chk("R10 head ready", int'(head_ready[1]), 1);
    chk("R11 commit ok", int'(commit_ok), 1);
    active = 4'b1101; #1;
    chk("R11 inactive thread", int'(commit_ok), 0);
    active = 4'b1111; #1;
  endtask

  task automatic t_retire();
    retire = 4'b0010; tick(); retire = '0; #1;
    chk("R8 R12 head after retire", seq_of(1), 101);
    chk("R8 thread free", free_of(1), 14);
    chk("R8 total free", int'(total_free), 14);
    retire = 4'b0010; tick(); retire = '0; #1;
    chk("R12 second head", seq_of(1), 102);
    retire = 4'b0010; tick(); retire = '0; #1;
    chk("R8 not ready ignored seq", seq_of(1), 102);
    chk("R8 not ready ignored free", free_of(1), 15);
    retire = 4'b1000; tick(); retire = '0; #1;
    chk("R8 empty retire ignored", int'(total_free), 15);
    alloc1(2, 200, 0, 0, "t2");
  endtask

  task automatic t_refuse();
    policy = 2'd2; #1;
    for (int i = 0; i < THRESH; i++) alloc1(0, i, 1, i, "t0 fill");
    chk("R5 at limit", free_of(0), 0);
    alloc_valid = 1; alloc_tid = 0; alloc_seq = 77; alloc_ready = 1; #1;
    chk("R7 err pulse", int'(alloc_err), 1);
    chk("R7 not accepted", int'(alloc_ok), 0);
    tick(); alloc_valid = 0; #1;
    chk("R7 err ends", int'(alloc_err), 0);
    chk("R7 total unchanged", int'(total_free), 8);
    chk("R7 head unchanged", seq_of(0), 0);
  endtask

  task automatic t_full();
    policy = 2'd0; #1;
    for (int i = 0; i < 8; i++) alloc1(3, 400 + i, 0, i, "t3 fill");
    chk("R5 total empty", int'(total_free), 0);
    chk("R5 t3 free", free_of(3), 8);
    alloc_valid = 1; alloc_tid = 3; alloc_seq = 999; #1;
    chk("R6 R7 total full refused", int'(alloc_err), 1);
    tick(); alloc_valid = 0; #1;
    chk("R7 no change when full", int'(total_free), 0);
  endtask

  task automatic t_saturate();
    policy = 2'd1; active = 4'b1111; #1;
    chk("R5 saturate t0", free_of(0), 0);
    chk("R5 saturate t3", free_of(3), 0);
    chk("R5 partial t1", free_of(1), 3);
    active = 4'b0001; #1;
    chk("R3 R5 single active", free_of(0), 10);
    policy = 2'd0; active = 4'b1111; #1;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < THRESH; i++) begin
      chk("R12 drain order", seq_of(0), i);
      retire = 4'b0001; tick(); retire = '0;
    end
    #1;
    chk("R9 drained", int'(head_valid[0]), 0);
    chk("R8 total after drain", int'(total_free), 6);
    for (int i = 0; i < 12; i++) begin
      alloc1(0, 300 + i, 1, (THRESH + i) % DEPTH, "wrap");
      chk("R12 wrap head", seq_of(0), 300 + i);
      chk("R11 ready head commits", int'(commit_ok), 1);
      retire = 4'b0001; tick(); retire = '0;
    end
    #1;
    chk("R12 empty after wrap", int'(head_valid[0]), 0);
    alloc1(0, 500, 1, 2, "pair");
    alloc_valid = 1; alloc_tid = 0; alloc_seq = 501; alloc_ready = 1;
    retire = 4'b0001;
    tick(); alloc_valid = 0; retire = '0; #1;
    chk("R8 same-cycle head", seq_of(0), 501);
    chk("R6 R8 same-cycle total", int'(total_free), 5);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle();
    policy = 2'd0; active = 4'b1111; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_policy();
    t_alloc_order();
    t_cmpl_empty();
    t_complete();
    t_retire();
    t_refuse();
    t_full();
    t_saturate();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule